// File: doc/BRIEF.md
# Channel-Select Conversion Sequencer

This block is the control sequencer that sits in front of a multiplexed successive-approximation converter. A host drives an active-low chip select, an active-low write strobe, a channel address and an address-enable line. A write with chip select low and address-enable high picks a new channel. The block then raises a settling flag and holds it for a fixed number of clock cycles while the analog multiplexer and amplifier settle. After that it issues a one-cycle start pulse, with the latched channel number, to the conversion engine.

A write with address-enable low keeps the previous channel and skips settling. Conversion then begins as soon as the write strobe returns high. The start moment is whichever comes later: the end of settling or the rising write strobe. While the settling or busy flag is high, further write commands are dropped. The busy flag stays high from the start pulse until the engine answers with a one-cycle done pulse.

All strobe and address inputs are asynchronous to the clock. They pass through a synchroniser chain of `SYNC_STAGES` flops, and edges are detected after it. With the default of two stages, a strobe edge takes effect on the third rising clock edge after it reaches the pins.

Top module: `chan_conv_sequencer`

## Requirements
- R1: While synchronous reset is high, and on the first cycle after it, `settling`, `busy` and `convStart` are 0 and `convChan` is 0.
- R2: A falling `wrN` with `csN` low and `addrEn` high loads `chanAddr` into `convChan`. `settling` goes to 1 on the third rising clock edge after the fall, and `busy` is 0 when it rises.
- R3: `settling` stays at 1 for exactly `SETTLE_CYCLES` clock cycles and then returns to 0.
- R4: If `wrN` rises while `settling` is 1, including on its last cycle, `convStart` is asserted in the first cycle in which `settling` is 0 again.
- R5: If `wrN` rises after `settling` has returned to 0, `convStart` is asserted on the third rising clock edge after the rise. Until then `busy` stays 0.
- R6: A falling `wrN` with `csN` low and `addrEn` low leaves `convChan` unchanged and never raises `settling`. `convStart` follows on the third rising clock edge after `wrN` rises.
- R7: `convStart` lasts exactly one cycle, and `busy` rises in that same cycle. `busy` stays 1 until the clock edge that samples `convDone` high, and is 0 from the next cycle on.
- R8: A write strobe that falls while `settling` or `busy` is 1 is ignored. It produces no extra `convStart`, and `convChan` does not change.
- R9: A falling `wrN` while `csN` is high does nothing: `settling` stays 0, no `convStart` follows, and `convChan` is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| csN | input | 1 | Chip select, active low, asynchronous |
| wrN | input | 1 | Write strobe, active low, asynchronous |
| chanAddr | input | ADDR_W | Channel address, captured on the write fall |
| addrEn | input | 1 | 1: load a new channel and settle; 0: keep the channel and skip settling |
| convDone | input | 1 | One-cycle completion pulse from the conversion engine |
| settling | output | 1 | Multiplexer settling in progress |
| busy | output | 1 | Conversion in progress |
| convStart | output | 1 | One-cycle start pulse to the conversion engine |
| convChan | output | ADDR_W | Channel currently selected |

## Verification
The hardest case to reach is a write strobe that rises in the very cycle the settling count runs out, or one cycle after it. In the first case the start has to come straight out of settling. In the second it has to come through the wait-for-rise path. Directed writes hold the strobe low for exactly `SETTLE_CYCLES` and `SETTLE_CYCLES`+1 cycles so that both sides of that boundary are covered. Random writes then spread the hold time across the whole settling window and also mix in address-enable, chip select and engine latency. Separate directed writes land while settling and while busy to show they are dropped.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_SETTLE,
    SQ_WAIT_RISE,
    SQ_START,
    SQ_CONV
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadChan;
    logic loadCnt;
    logic tick;
    logic clrRose;
  } seqCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic wrFall;
    logic wrRise;
    logic csLow;
    logic addrEn;
    logic cntZero;
    logic wrRose;
  } seqStat_t;

endpackage

// File: rtl/seq_datapath.sv
module seq_datapath
  import conv_seq_pkg::*;
#(
  parameter int ADDR_W        = 5,
  parameter int SETTLE_CYCLES = 2500,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csN,
  input  logic              wrN,
  input  logic [ADDR_W-1:0] chanAddr,
  input  logic              addrEn,
  input  seqCtrl_t          ctrl,
  output seqStat_t          stat,
  output logic [ADDR_W-1:0] chanQ
);

  localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYCLES - 1);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] csPipe;
  logic [SYNC_STAGES-1:0] wrPipe;
  logic [SYNC_STAGES-1:0] aenPipe;
  logic [ADDR_W-1:0]      addrPipe [SYNC_STAGES];
  logic                   wrPrev;
  logic [CNT_W-1:0]       cnt;
  logic                   wrRoseQ;

  // synchroniser chains, one flop per stage
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) begin
            csPipe[gi]   <= 1'b1;
            wrPipe[gi]   <= 1'b1;
            aenPipe[gi]  <= 1'b0;
            addrPipe[gi] <= '0;
          end else begin
            csPipe[gi]   <= csN;
            wrPipe[gi]   <= wrN;
            aenPipe[gi]  <= addrEn;
            addrPipe[gi] <= chanAddr;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) begin
            csPipe[gi]   <= 1'b1;
            wrPipe[gi]   <= 1'b1;
            aenPipe[gi]  <= 1'b0;
            addrPipe[gi] <= '0;
          end else begin
            csPipe[gi]   <= csPipe[gi-1];
            wrPipe[gi]   <= wrPipe[gi-1];
            aenPipe[gi]  <= aenPipe[gi-1];
            addrPipe[gi] <= addrPipe[gi-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) wrPrev <= 1'b1;
    else     wrPrev <= wrPipe[LAST];
  end

  // channel register
  always_ff @(posedge clk) begin
    if (rst)               chanQ <= '0;
    else if (ctrl.loadChan) chanQ <= addrPipe[LAST];
  end

  // settling down-counter
  always_ff @(posedge clk) begin
    if (rst)                         cnt <= '0;
    else if (ctrl.loadCnt)           cnt <= CNT_LOAD;
    else if (ctrl.tick && cnt != '0) cnt <= cnt - 1'b1;
  end

  // remembers a write rise seen during settling
  always_ff @(posedge clk) begin
    if (rst)               wrRoseQ <= 1'b0;
    else if (ctrl.clrRose) wrRoseQ <= 1'b0;
    else if (stat.wrRise)  wrRoseQ <= 1'b1;
  end

  always_comb begin
    stat.wrFall  = wrPrev & ~wrPipe[LAST];
    stat.wrRise  = ~wrPrev & wrPipe[LAST];
    stat.csLow   = ~csPipe[LAST];
    stat.addrEn  = aenPipe[LAST];
    stat.cntZero = (cnt == '0);
    stat.wrRose  = wrRoseQ;
  end

endmodule

// File: rtl/seq_control.sv
module seq_control
  import conv_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  seqStat_t stat,
  input  logic     convDone,
  output seqCtrl_t ctrl,
  output logic     settling,
  output logic     busy,
  output logic     convStart
);

  seqState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= SQ_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    unique case (state)
      SQ_IDLE: begin
        if (stat.wrFall && stat.csLow) begin
          if (stat.addrEn) begin
            ctrl.loadChan = 1'b1;
            ctrl.loadCnt  = 1'b1;
            ctrl.clrRose  = 1'b1;
            stateNext     = SQ_SETTLE;
          end else begin
            stateNext     = SQ_WAIT_RISE;
          end
        end
      end
      SQ_SETTLE: begin
        ctrl.tick = 1'b1;
        if (stat.cntZero)
          stateNext = (stat.wrRose || stat.wrRise) ? SQ_START : SQ_WAIT_RISE;
      end
      SQ_WAIT_RISE: begin
        if (stat.wrRise) stateNext = SQ_START;
      end
      SQ_START: stateNext = SQ_CONV;
      SQ_CONV: begin
        if (convDone) stateNext = SQ_IDLE;
      end
      default: stateNext = SQ_IDLE;
    endcase
  end

  assign settling  = (state == SQ_SETTLE);
  assign convStart = (state == SQ_START);
  assign busy      = (state == SQ_START) || (state == SQ_CONV);

endmodule

// File: rtl/chan_conv_sequencer.sv
module chan_conv_sequencer
  import conv_seq_pkg::*;
#(
  parameter int ADDR_W        = 5,
  parameter int SETTLE_CYCLES = 2500,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csN,
  input  logic              wrN,
  input  logic [ADDR_W-1:0] chanAddr,
  input  logic              addrEn,
  input  logic              convDone,
  output logic              settling,
  output logic              busy,
  output logic              convStart,
  output logic [ADDR_W-1:0] convChan
);

  seqCtrl_t ctrl;
  seqStat_t stat;

  seq_datapath #(
    .ADDR_W       (ADDR_W),
    .SETTLE_CYCLES(SETTLE_CYCLES),
    .SYNC_STAGES  (SYNC_STAGES)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .csN     (csN),
    .wrN     (wrN),
    .chanAddr(chanAddr),
    .addrEn  (addrEn),
    .ctrl    (ctrl),
    .stat    (stat),
    .chanQ   (convChan)
  );

  seq_control u_ctl (
    .clk      (clk),
    .rst      (rst),
    .stat     (stat),
    .convDone (convDone),
    .ctrl     (ctrl),
    .settling (settling),
    .busy     (busy),
    .convStart(convStart)
  );

endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int ADDR_W        = 5,
  parameter int SETTLE_CYCLES = 2500
) (
  input logic              clk,
  input logic              rst,
  input logic              convDone,
  input logic              settling,
  input logic              busy,
  input logic              convStart,
  input logic [ADDR_W-1:0] convChan
);

  int unsigned stlRun;

  always_ff @(posedge clk) begin
    if (rst)           stlRun <= 0;
    else if (settling) stlRun <= stlRun + 1;
    else               stlRun <= 0;
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!settling && !busy && !convStart && convChan == '0)); // R1

  AST_SETTLE_IDLE_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(settling) |-> !busy); // R2

  AST_SETTLE_LIMIT: assert property (@(posedge clk) disable iff (rst)
    settling |-> (stlRun < SETTLE_CYCLES)); // R3

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(settling && busy)); // R4

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    convStart |=> !convStart); // R7

  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    convStart |-> busy); // R7

  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (busy && !convStart && convDone) |=> !busy); // R7

  AST_CHAN_HELD: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(convChan)); // R8

endmodule

bind chan_conv_sequencer seq_checker #(
  .ADDR_W       (ADDR_W),
  .SETTLE_CYCLES(SETTLE_CYCLES)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .convDone (convDone),
  .settling (settling),
  .busy     (busy),
  .convStart(convStart),
  .convChan (convChan)
);

// File: tb/chan_conv_sequencer_tb.sv
`timescale 1ns/1ps
module chan_conv_sequencer_tb;

  localparam int AW = 5;
  localparam int S  = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          csN = 1'b1;
  logic          wrN = 1'b1;
  logic [AW-1:0] chanAddr = '0;
  logic          addrEn = 1'b0;
  logic          convDone = 1'b0;
  logic          settling, busy, convStart;
  logic [AW-1:0] convChan;

  always #2 clk = ~clk;  // 250 MHz

  chan_conv_sequencer #(.ADDR_W(AW), .SETTLE_CYCLES(S), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .csN(csN), .wrN(wrN), .chanAddr(chanAddr),
    .addrEn(addrEn), .convDone(convDone), .settling(settling), .busy(busy),
    .convStart(convStart), .convChan(convChan)
  );

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor and conversion-engine model, sampled on the falling edge
  int stlRiseC = -100, stlFallC = -100, startC = -100, busyRiseC = -100, busyFallC = -100;
  int startN = 0;
  int doubleStart = 0;
  int engLat = 4;
  int doneAt = -1;
  logic [AW-1:0] startChan = '0;
  logic stlQ = 0, busyQ = 0, startQ = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (settling && !stlQ) stlRiseC = cyc;
      if (!settling && stlQ) stlFallC = cyc;
      if (busy && !busyQ)    busyRiseC = cyc;
      if (!busy && busyQ)    busyFallC = cyc;
      if (convStart) begin
        startC    = cyc;
        startN    = startN + 1;
        startChan = convChan;
        doneAt    = cyc + engLat;
        if (startQ) doubleStart = doubleStart + 1;
      end
      convDone <= (cyc == doneAt);
      stlQ   = settling;
      busyQ  = busy;
      startQ = convStart;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  logic [AW-1:0] modelChan = '0;

  function automatic int expStart(input int t0, input int hold, input bit aEn);
    if (!aEn) return t0 + hold + 3;
    return (hold <= S) ? t0 + S + 3 : t0 + hold + 3;
  endfunction

  // one write command: strobe held low for 'hold' cycles, engine latency 'lat'
  task automatic cmd(input bit aEn, input logic [AW-1:0] ch, input bit csHigh,
                     input int hold, input int lat);
    int t0, n0, es;
    engLat = lat;
    n0 = startN;
    @(negedge clk);
    csN = csHigh; chanAddr = ch; addrEn = aEn; wrN = 1'b0;
    t0 = cyc;
    repeat (hold) @(negedge clk);
    wrN = 1'b1;
    repeat (2) @(negedge clk);
    csN = 1'b1; chanAddr = ~ch; addrEn = ~aEn;
    repeat (S + lat + 10) @(negedge clk);
    if (csHigh) begin
      chk(startN == n0, "R9 start count", startN, n0);
      chk(stlRiseC < t0, "R9 settling stayed low", stlRiseC, t0);
      chk(convChan == modelChan, "R9 channel kept", convChan, modelChan);
    end else if (aEn) begin
      es = expStart(t0, hold, 1'b1);
      chk(stlRiseC == t0 + 3, "R2 settling rise", stlRiseC, t0 + 3);
      chk(stlFallC - stlRiseC == S, "R3 settling length", stlFallC - stlRiseC, S);
      chk(startC == es, (hold <= S) ? "R4 start at settle end" : "R5 start after rise",
          startC, es);
      chk(startChan == ch, "R2 channel captured", startChan, ch);
      chk(startN == n0 + 1, "R7 one start", startN, n0 + 1);
      chk(busyRiseC == startC, "R7 busy with start", busyRiseC, startC);
      chk(busyFallC == startC + lat + 1, "R7 busy release", busyFallC, startC + lat + 1);
      modelChan = ch;
    end else begin
      es = expStart(t0, hold, 1'b0);
      chk(stlRiseC < t0, "R6 no settling", stlRiseC, t0);
      chk(startC == es, "R6 start after rise", startC, es);
      chk(startChan == modelChan, "R6 channel kept", startChan, modelChan);
      chk(busyFallC == startC + lat + 1, "R7 busy release", busyFallC, startC + lat + 1);
    end
  endtask

  task automatic pulseWr(input logic [AW-1:0] ch);
    csN = 1'b0; addrEn = 1'b1; chanAddr = ch; wrN = 1'b0;
    repeat (3) @(negedge clk);
    wrN = 1'b1;
    repeat (2) @(negedge clk);
    csN = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int n0;
    void'($urandom(32'h5EC0_0A1D));
    repeat (5) @(negedge clk);
    chk(!settling && !busy && !convStart, "R1 flags in reset", {settling, busy, convStart}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(convChan == '0, "R1 channel 0", convChan, 0);
    chk(!settling && !busy && !convStart, "R1 flags after reset", {settling, busy, convStart}, 0);

    // directed: rise well inside, exactly at end, one past end, late
    cmd(1'b1, 5'd7,  1'b0, 2,     5);
    cmd(1'b1, 5'd19, 1'b0, S,     3);
    cmd(1'b1, 5'd31, 1'b0, S + 1, 6);
    cmd(1'b1, 5'd1,  1'b0, S + 5, 2);
    cmd(1'b0, 5'd22, 1'b0, 4,     4);
    cmd(1'b1, 5'd9,  1'b1, 3,     4);

    // R8: writes while settling and while busy are dropped
    engLat = 25;
    n0 = startN;
    @(negedge clk);
    csN = 1'b0; addrEn = 1'b1; chanAddr = 5'd12; wrN = 1'b0;
    repeat (2) @(negedge clk);
    wrN = 1'b1;
    repeat (5) @(negedge clk);
    pulseWr(5'd27);
    while (!busy) @(negedge clk);
    repeat (2) @(negedge clk);
    pulseWr(5'd3);
    repeat (S + 40) @(negedge clk);
    chk(startN == n0 + 1, "R8 extra writes dropped", startN, n0 + 1);
    chk(convChan == 5'd12, "R8 channel unchanged", convChan, 12);
    modelChan = 5'd12;

    // random mix
    for (int i = 0; i < 40; i++) begin
      bit aEn, csH;
      int hold, lat;
      logic [AW-1:0] ch;
      aEn  = 1'($urandom % 2);
      csH  = (($urandom % 8) == 0);
      ch   = AW'($urandom);
      hold = 1 + int'($urandom % (S + 6));
      lat  = 2 + int'($urandom % 14);
      cmd(aEn, ch, csH, hold, lat);
    end

    chk(doubleStart == 0, "R7 start one cycle", doubleStart, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule